// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block makes the serial clock that a shift engine uses to move data on and off a synchronous serial link. It runs on the system clock and advances only on ticks of a 12 MHz enable pulse. The timing is set by a 16-bit divisor register. When the link is idle, the clock line rests at a level that software chooses. Each request asks for one bit period. The block answers by inverting the line twice. From a low rest level this gives a high pulse. From a high rest level it gives a low pulse. The line always comes back to its rest level.

Each half period lasts divisor + 1 ticks. The clock frequency is therefore the tick rate divided by 2 × (1 + divisor): a divisor of zero gives half the tick rate, and the full 16-bit value gives roughly 91.55 Hz. The block raises one-cycle strobes on the first (leading) and second (trailing) inversion of each period, and on every rising and every falling transition. These let the shift engine launch and sample data on whichever edge it was asked to use. A busy flag and a done pulse tell the requester when the period has finished.

Top module: `sclk_gen`

## Requirements
- R1: After reset the clock output is low, busy and done are low, and all four strobes are low.
- R2: An idle-level write (idleWr high for one cycle) sets sclk to idleIn on the next clock edge when busy is low. An idle-level write while busy is high is ignored, and sclk still returns to the previous rest level.
- R3: A request (cycleReq high) while busy is low starts a period. Busy rises on the next edge. The period is exactly two inversions of sclk. Busy falls and done pulses for one cycle in the same cycle as the second inversion, leaving sclk at its rest level.
- R4: Each half period lasts divisor + 1 ticks of tickEn, counted from the cycle after the request is accepted. Cycles with tickEn low do not advance the clock.
- R5: leadStb is high for one cycle together with the first inversion, and trailStb with the second inversion. There is exactly one of each per period, and they are never high together.
- R6: riseStb is high exactly in the cycle after sclk goes from 0 to 1, and fallStb in the cycle after sclk goes from 1 to 0.
- R7: A divisor write (divWr with divIn) during a period does not change that period. It applies to the next request.
- R8: A request made while busy is high is ignored: no extra period and no extra strobes.
- R9: While a period runs, sclk changes only in cycles that carry a rise or fall strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 12 MHz tick enable, one system cycle wide |
| cycleReq | input | 1 | Request one serial clock period |
| divWr | input | 1 | Write strobe for the divisor register |
| divIn | input | 16 | New divisor value |
| idleWr | input | 1 | Write strobe for the rest level |
| idleIn | input | 1 | New rest level of the clock |
| sclk | output | 1 | Serial clock output |
| busy | output | 1 | A period is in progress |
| done | output | 1 | One-cycle pulse at the end of a period |
| riseStb | output | 1 | sclk has just risen |
| fallStb | output | 1 | sclk has just fallen |
| leadStb | output | 1 | First inversion of the period |
| trailStb | output | 1 | Second inversion of the period |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that idle-level writes only move sclk while busy is low, so a stable-clock rule is checked only when the previous cycle was busy. The stimulus keeps every idle write, divisor write and request one cycle wide and applies them on the falling edge. The tick enable comes from a free-running counter, so half periods include clocks with no tick. Busy-time requests, divisor writes and idle writes are placed well inside a running period, so each one sees the state it is meant to test.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_TRAIL = 2'd2
  } clkPhase_t;

  typedef struct packed {
    logic takeDiv;   // snapshot divisor for this period
    logic loadCnt;   // reload half-period counter
    logic decCnt;    // count one tick down
    logic toggle;    // invert the clock line
    logic lead;      // first inversion of the period
    logic trail;     // second inversion of the period
  } clkCtl_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycleReq,
  input  logic    tickEn,
  input  logic    cntZero,
  output clkCtl_t ctl,
  output logic    busy,
  output logic    done
);
  clkPhase_t phase, phaseNext;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (cycleReq) begin
          ctl.takeDiv = 1'b1;
          ctl.loadCnt = 1'b1;
          phaseNext   = PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (tickEn) begin
          if (cntZero) begin
            ctl.toggle  = 1'b1;
            ctl.lead    = 1'b1;
            ctl.loadCnt = 1'b1;
            phaseNext   = PH_TRAIL;
          end else begin
            ctl.decCnt = 1'b1;
          end
        end
      end
      PH_TRAIL: begin
        if (tickEn) begin
          if (cntZero) begin
            ctl.toggle = 1'b1;
            ctl.trail  = 1'b1;
            phaseNext  = PH_IDLE;
          end else begin
            ctl.decCnt = 1'b1;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= ctl.trail;
    end
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/sclk_dpath.sv
module sclk_dpath
  import sclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkCtl_t          ctl,
  input  logic             busy,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divIn,
  input  logic             idleWr,
  input  logic             idleIn,
  output logic             cntZero,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb,
  output logic             leadStb,
  output logic             trailStb
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] halfCnt;
  logic             idleAccept;

  assign idleAccept = idleWr && !busy;
  assign cntZero    = (halfCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg  <= '0;
      curDiv  <= '0;
      halfCnt <= '0;
    end else begin
      if (divWr) divReg <= divIn;
      if (ctl.takeDiv) curDiv <= divReg;
      if (ctl.loadCnt) halfCnt <= ctl.takeDiv ? divReg : curDiv;
      else if (ctl.decCnt) halfCnt <= halfCnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclk     <= 1'b0;
      riseStb  <= 1'b0;
      fallStb  <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else begin
      if (ctl.toggle) sclk <= ~sclk;
      else if (idleAccept) sclk <= idleIn;
      riseStb  <= ctl.toggle && !sclk;
      fallStb  <= ctl.toggle && sclk;
      leadStb  <= ctl.lead;
      trailStb <= ctl.trail;
    end
  end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cycleReq,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divIn,
  input  logic             idleWr,
  input  logic             idleIn,
  output logic             sclk,
  output logic             busy,
  output logic             done,
  output logic             riseStb,
  output logic             fallStb,
  output logic             leadStb,
  output logic             trailStb
);
  clkCtl_t ctl;
  logic    cntZero;

  sclk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycleReq (cycleReq),
    .tickEn   (tickEn),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  sclk_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .busy     (busy),
    .divWr    (divWr),
    .divIn    (divIn),
    .idleWr   (idleWr),
    .idleIn   (idleIn),
    .cntZero  (cntZero),
    .sclk     (sclk),
    .riseStb  (riseStb),
    .fallStb  (fallStb),
    .leadStb  (leadStb),
    .trailStb (trailStb)
  );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
  input logic clk,
  input logic rstN,
  input logic cycleReq,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic riseStb,
  input logic fallStb,
  input logic leadStb,
  input logic trailStb
);
  // R6
  rise_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (sclk && !$past(sclk)));
  // R6
  fall_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!sclk && $past(sclk)));
  // R5
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({leadStb, trailStb}));
  // R5
  lead_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStb |-> (busy && $countones({riseStb, fallStb}) == 1));
  // R3
  end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && trailStb));
  // R3
  start_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cycleReq));
  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !riseStb && !fallStb) |-> $stable(sclk));
endmodule

bind sclk_gen sclk_gen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cycleReq (cycleReq),
  .sclk     (sclk),
  .busy     (busy),
  .done     (done),
  .riseStb  (riseStb),
  .fallStb  (fallStb),
  .leadStb  (leadStb),
  .trailStb (trailStb)
);

// File: tb/tb_sclk_gen.sv
`timescale 1ns/1ps
module tb_sclk_gen;
  localparam int DIV_W    = 16;
  localparam int TICK_DIV = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             cycleReq = 1'b0;
  logic             divWr = 1'b0;
  logic [DIV_W-1:0] divIn = '0;
  logic             idleWr = 1'b0;
  logic             idleIn = 1'b0;
  logic sclk, busy, done, riseStb, fallStb, leadStb, trailStb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit isLead;
    bit isRise;
    int ticks;
    bit level;
  } edgeExp_t;
  edgeExp_t expQ[$];

  always #2.5 clk = ~clk;

  sclk_gen #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cycleReq(cycleReq),
    .divWr(divWr), .divIn(divIn), .idleWr(idleWr), .idleIn(idleIn),
    .sclk(sclk), .busy(busy), .done(done), .riseStb(riseStb),
    .fallStb(fallStb), .leadStb(leadStb), .trailStb(trailStb)
  );

  int tickPhase = 0;
  always @(posedge clk) begin
    tickPhase <= (tickPhase == TICK_DIV-1) ? 0 : tickPhase + 1;
    tickEn    <= (tickPhase == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares strobes against the scoreboard
  int tickCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (leadStb || trailStb) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected edge strobe", 1, 0);
        end else begin
          edgeExp_t e;
          e = expQ.pop_front();
          check(leadStb == e.isLead, "R5 lead/trail order", leadStb, e.isLead);
          check(riseStb == e.isRise && fallStb == !e.isRise, "R6 edge direction",
                riseStb, e.isRise);
          check(tickCnt == e.ticks, "R4 tick count", tickCnt, e.ticks);
          check(sclk == e.level, "R3 line level", sclk, e.level);
          if (trailStb) check(done && !busy, "R3 done with second inversion", done, 1);
        end
      end
      if (busy) tickCnt = tickCnt + (tickEn ? 1 : 0);
      else tickCnt = 0;
    end
  end

  bit curLvl = 0;

  task automatic writeIdle(input bit lvl);
    @(negedge clk); idleWr = 1; idleIn = lvl;
    @(negedge clk); idleWr = 0; idleIn = 0;
    check(sclk == lvl, "R2 idle level applied", sclk, lvl);
    curLvl = lvl;
  endtask

  task automatic writeDiv(input int d);
    @(negedge clk); divWr = 1; divIn = DIV_W'(d);
    @(negedge clk); divWr = 0; divIn = '0;
  endtask

  // mode: 0 plain, 1 divisor write mid-period, 2 extra request, 3 idle write mid-period
  task automatic runPeriod(input int d, input int mode, input int midVal);
    edgeExp_t e1, e2;
    e1.isLead = 1; e1.isRise = (curLvl == 0); e1.ticks = d + 1;       e1.level = !curLvl;
    e2.isLead = 0; e2.isRise = (curLvl == 1); e2.ticks = 2 * (d + 1); e2.level = curLvl;
    expQ.push_back(e1);
    expQ.push_back(e2);
    @(negedge clk); cycleReq = 1;
    @(negedge clk); cycleReq = 0;
    check(busy == 1, "R3 busy after request", busy, 1);
    repeat (2) @(negedge clk);
    if (mode == 1) begin divWr = 1; divIn = DIV_W'(midVal); @(negedge clk); divWr = 0; end
    if (mode == 2) begin cycleReq = 1; @(negedge clk); cycleReq = 0; end
    if (mode == 3) begin idleWr = 1; idleIn = !curLvl; @(negedge clk); idleWr = 0; end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!busy && sclk == curLvl, "R3 rest after period", sclk, curLvl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 0 && busy == 0 && done == 0, "R1 reset outputs", {sclk, busy, done}, 0);
    check({riseStb, fallStb, leadStb, trailStb} == 0, "R1 reset strobes",
          {riseStb, fallStb, leadStb, trailStb}, 0);
    rstN = 1;
    @(negedge clk);
    // fastest divisor from low rest
    runPeriod(0, 0, 0);
    // larger divisor from high rest
    writeIdle(1);
    writeDiv(3);
    runPeriod(3, 0, 0);
    writeIdle(0);
    writeDiv(5);
    runPeriod(5, 0, 0);
    // R7: divisor written during a period applies next time
    writeDiv(4);
    runPeriod(4, 1, 9);
    runPeriod(9, 0, 0);
    // R8: second request while busy is dropped
    writeDiv(2);
    runPeriod(2, 2, 0);
    repeat (20) @(negedge clk);
    check(busy == 0, "R8 no extra period", busy, 0);
    // R2: idle write while busy is ignored
    writeIdle(1);
    runPeriod(2, 3, 0);
    repeat (3) @(negedge clk);
    check(sclk == 1, "R2 busy idle write ignored", sclk, 1);
    writeDiv(16'h0020);
    runPeriod(32, 0, 0);
    check(expQ.size() == 0, "R5 all expected edges seen", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule